// File: doc/BRIEF.md
# Serial Memory Command Engine

This block is the slave side of a serial memory reached over a four-wire SPI link in mode 0. Each transaction opens when chip-select goes low. The first byte on the serial input is an opcode. Memory commands then take a 16-bit address, after which data bytes stream out of the internal byte array or into it. The array holds `2**ADDR_W` bytes, so `ADDR_W = 14` gives 16 KB. The default keeps the array small. The block's clock samples the serial pins through synchronisers, so the SPI clock must run several times slower than `clk`.

Writes are staged in a small buffer. They reach the array only after chip-select rises, during a fixed busy window. An external checker decides, for each byte, whether its address may be written. The block reports the current protection level to that checker and presents each candidate address on `chk_addr`.

The serial side has no back-pressure. The master clocks bytes whenever it likes. The only throttle is the busy window, during which commands other than status read are dropped.

Top module: `smem_cmd_engine`

## Requirements
- R1: Opcode 0x03 followed by a two-byte address (high byte first) starts a read. Address bits at and above `ADDR_W` are ignored. Each data byte leaves `spi_miso` most significant bit first, and values on `spi_mosi` during the data phase have no effect.
- R2: While chip-select stays low, a read keeps going at the next address. After the highest address `2**ADDR_W-1` it continues from address 0.
- R3: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Opcode 0x02 (write) and opcode 0x01 (status write) are dropped when the latch is clear.
- R4: An accepted write stores its data bytes at consecutive addresses from the given address, wrapping at the top of the array. Nothing is stored unless chip-select rises right after a whole byte and at least one data byte arrived. Only the first `BUF_DEPTH` data bytes are kept.
- R5: Each staged byte lands only if `chk_ok` is high while its address is shown on `chk_addr`. The bench checker treats level 1 as the top quarter, level 2 as the top half and level 3 as the whole array.
- R6: Opcode 0x05 returns the status byte: bit 0 busy, bit 1 write-enable latch, bits 3:2 protection level, bits 7:4 zero. Every further byte in the same transaction returns the live status again.
- R7: An accepted status write copies bits 3:2 of its first data byte into the protection level. This level also drives `prot_level`.
- R8: The write-enable latch clears when chip-select rises at the end of an accepted write or status write, whether or not any data was committed.
- R9: A committed write sets busy for `BUSY_CYCLES` clock cycles. While busy, every opcode except 0x05 is dropped and `spi_miso` stays low for the rest of that transaction.
- R10: `spi_miso` is low while chip-select is high. While it is driven, it changes only after a falling SPI clock edge.
- R11: After reset the status byte reads 0x00 and the array reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, several times the SPI clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI clock, idle low |
| spi_cs_n | input | 1 | Chip-select, active low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| prot_level | output | 2 | Current protection level for the external checker |
| chk_addr | output | ADDR_W | Array address of the byte being committed |
| chk_ok | input | 1 | High when the address on `chk_addr` may be written |

## Verification
The hardest state to reach from the pins is a command arriving inside the busy window. The window is only open after a committed write, and a single SPI transaction needs a large share of its length. The bench issues a write-enable and a read right after a commit, while busy is still high. It then confirms through status reads that the latch stayed clear and the read returned only zeros. A chip-select rise three bits into a data byte is produced by clocking partial bytes by hand. The whole array is swept by block writes and then read back in one continuous read that crosses the top address.

// File: rtl/smem_pkg.sv
package smem_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    S_CMD,
    S_ADDR,
    S_RD,
    S_WR,
    S_SR,
    S_SW,
    S_IGN
  } eng_state_t;
endpackage

// File: rtl/smem_sync.sv
module smem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_high,
  output logic cs_rise,
  output logic mosi_s
);
  logic [STAGES-1:0] sck_p, cs_p, mosi_p;
  logic sck_d, cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sck_p  <= {sck_p[STAGES-2:0], sck};
      cs_p   <= {cs_p[STAGES-2:0], cs_n};
      mosi_p <= {mosi_p[STAGES-2:0], mosi};
      sck_d  <= sck_p[STAGES-1];
      cs_d   <= cs_p[STAGES-1];
    end
  end

  assign sck_rise = sck_p[STAGES-1] & ~sck_d;
  assign sck_fall = ~sck_p[STAGES-1] & sck_d;
  assign cs_high  = cs_p[STAGES-1];
  assign cs_rise  = cs_p[STAGES-1] & ~cs_d;
  assign mosi_s   = mosi_p[STAGES-1];
endmodule

// File: rtl/smem_array.sv
module smem_array #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int WORDS = 1 << ADDR_W;
  logic [7:0] mem [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= 8'h00;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/smem_commit.sv
module smem_commit #(
  parameter int ADDR_W      = 8,
  parameter int BUF_DEPTH   = 8,
  parameter int BUSY_CYCLES = 600,
  localparam int CNT_W = $clog2(BUF_DEPTH + 1),
  localparam int IDX_W = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [IDX_W-1:0]  push_idx,
  input  logic [7:0]        push_data,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  count,
  input  logic              chk_ok,
  output logic [ADDR_W-1:0] chk_addr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic              busy
);
  localparam int TMR_W = $clog2(BUSY_CYCLES + 1);

  logic [7:0]        stage [BUF_DEPTH];
  logic              busy_q;
  logic [TMR_W-1:0]  tmr;
  logic [CNT_W-1:0]  idx, n_q;
  logic [ADDR_W-1:0] base_q;
  logic              active;

  always_ff @(posedge clk) begin
    if (push) stage[push_idx] <= push_data;
  end

  assign active    = busy_q && (idx < n_q);
  assign chk_addr  = base_q + ADDR_W'(idx);
  assign mem_we    = active && chk_ok;
  assign mem_waddr = chk_addr;
  assign mem_wdata = stage[idx[IDX_W-1:0]];
  assign busy      = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tmr    <= '0;
      idx    <= '0;
      n_q    <= '0;
      base_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      tmr    <= TMR_W'(BUSY_CYCLES - 1);
      idx    <= '0;
      n_q    <= count;
      base_q <= base;
    end else if (busy_q) begin
      if (active) idx <= idx + 1'b1;
      if (tmr == '0) busy_q <= 1'b0;
      else tmr <= tmr - 1'b1;
    end
  end

  // R9: busy cannot drop while cycles of the window remain
  a_r9_busy_span: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && tmr != '0 && !start) |=> busy_q);

  // R4: array writes only happen while a commit is running
  a_r4_write_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(start) || $past(busy_q)));
endmodule

// File: rtl/smem_cmd_engine.sv
module smem_cmd_engine
  import smem_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int BUF_DEPTH   = 8,
  parameter int BUSY_CYCLES = 600,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [1:0]        prot_level,
  output logic [ADDR_W-1:0] chk_addr,
  input  logic              chk_ok
);
  localparam int CNT_W = $clog2(BUF_DEPTH + 1);
  localparam int IDX_W = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;

  logic sck_rise, sck_fall, cs_high, cs_rise, mosi_s;

  smem_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_high(cs_high),
    .cs_rise(cs_rise), .mosi_s(mosi_s)
  );

  eng_state_t        state;
  logic [2:0]        cnt;
  logic [6:0]        rx;
  logic [7:0]        tx_byte;
  logic              miso_q;
  logic              wel, wel_clr_pend, wsr_done, rd_mode, ab;
  logic [ADDR_W-1:0] ptr;
  logic [CNT_W-1:0]  nbytes;
  logic [1:0]        level;
  logic              busy;

  logic [7:0]        byte_in;
  logic              byte_done;
  logic [ADDR_W-1:0] addr_now;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;
  logic [7:0]        status;
  logic              commit_start, push;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [7:0]        mem_wdata;

  assign byte_in   = {rx, mosi_s};
  assign byte_done = sck_rise && !cs_high && (cnt == 3'd7);
  assign addr_now  = ADDR_W'({ptr, byte_in});
  assign rd_addr   = (state == S_ADDR) ? addr_now : ptr;
  assign status    = {4'b0000, level, wel, busy};

  assign commit_start = cs_rise && (state == S_WR) && (cnt == 3'd0) && (nbytes != '0);
  assign push = byte_done && (state == S_WR) && (nbytes < CNT_W'(BUF_DEPTH));

  smem_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  smem_commit #(.ADDR_W(ADDR_W), .BUF_DEPTH(BUF_DEPTH), .BUSY_CYCLES(BUSY_CYCLES)) u_commit (
    .clk(clk), .rst_n(rst_n), .push(push), .push_idx(nbytes[IDX_W-1:0]),
    .push_data(byte_in), .start(commit_start), .base(ptr), .count(nbytes),
    .chk_ok(chk_ok), .chk_addr(chk_addr), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_CMD;
      cnt          <= '0;
      rx           <= '0;
      tx_byte      <= '0;
      miso_q       <= 1'b0;
      wel          <= 1'b0;
      wel_clr_pend <= 1'b0;
      wsr_done     <= 1'b0;
      rd_mode      <= 1'b0;
      ab           <= 1'b0;
      ptr          <= '0;
      nbytes       <= '0;
      level        <= 2'b00;
    end else if (cs_high) begin
      state    <= S_CMD;
      cnt      <= '0;
      miso_q   <= 1'b0;
      ab       <= 1'b0;
      wsr_done <= 1'b0;
      if (cs_rise && wel_clr_pend) begin
        wel          <= 1'b0;
        wel_clr_pend <= 1'b0;
      end
    end else begin
      if (sck_rise) begin
        rx  <= byte_in[6:0];
        cnt <= cnt + 3'd1;
        if (cnt == 3'd7) begin
          case (state)
            S_CMD: begin
              if (busy && byte_in != OP_RDSR) begin
                state <= S_IGN;
              end else begin
                case (byte_in)
                  OP_WREN: begin wel <= 1'b1; state <= S_IGN; end
                  OP_WRDI: begin wel <= 1'b0; state <= S_IGN; end
                  OP_RDSR: begin tx_byte <= status; state <= S_SR; end
                  OP_WRSR: begin
                    state <= wel ? S_SW : S_IGN;
                    if (wel) wel_clr_pend <= 1'b1;
                  end
                  OP_READ: begin rd_mode <= 1'b1; ab <= 1'b0; state <= S_ADDR; end
                  OP_WRITE: begin
                    rd_mode <= 1'b0;
                    ab      <= 1'b0;
                    state   <= wel ? S_ADDR : S_IGN;
                    if (wel) wel_clr_pend <= 1'b1;
                  end
                  default: state <= S_IGN;
                endcase
              end
            end
            S_ADDR: begin
              if (!ab) begin
                ptr <= addr_now;
                ab  <= 1'b1;
              end else if (rd_mode) begin
                tx_byte <= rd_data;
                ptr     <= addr_now + 1'b1;
                state   <= S_RD;
              end else begin
                ptr    <= addr_now;
                nbytes <= '0;
                state  <= S_WR;
              end
            end
            S_RD: begin
              tx_byte <= rd_data;
              ptr     <= ptr + 1'b1;
            end
            S_SR: tx_byte <= status;
            S_SW: begin
              if (!wsr_done) begin
                level    <= byte_in[3:2];
                wsr_done <= 1'b1;
              end
            end
            S_WR: begin
              if (nbytes < CNT_W'(BUF_DEPTH)) nbytes <= nbytes + 1'b1;
            end
            default: ;
          endcase
        end
      end
      if (sck_fall && (state == S_RD || state == S_SR)) miso_q <= tx_byte[~cnt];
    end
  end

  assign spi_miso   = miso_q;
  assign prot_level = level;

  // R2: the read pointer wraps from the top address to zero
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && state == S_RD && ptr == '1) |=> (ptr == '0));

  // R9: opcodes other than status read are dropped while busy
  a_r9_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && state == S_CMD && busy && byte_in != OP_RDSR) |=> (state == S_IGN));

  // R3: a write opcode without the latch goes nowhere
  a_r3_write_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && state == S_CMD && byte_in == OP_WRITE && !wel) |=> (state == S_IGN));

  // R8: a commit only begins out of an enabled transaction
  a_r8_commit_had_wel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));

  // R10: the output is quiet once chip-select is seen high
  a_r10_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_high |=> !spi_miso);
endmodule

// File: tb/tb_smem_cmd_engine.sv
module tb_smem_cmd_engine;
  localparam int AW = 8;
  localparam int N = 1 << AW;
  localparam int DEP = 8;
  localparam int BUSY = 600;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso;
  logic [1:0] plev;
  logic [AW-1:0] caddr;
  logic cok;

  always #10 clk = ~clk;

  function automatic logic hit(input int a, input logic [1:0] l);
    case (l)
      2'd0: return 1'b0;
      2'd1: return a >= (N * 3) / 4;
      2'd2: return a >= N / 2;
      default: return 1'b1;
    endcase
  endfunction

  assign cok = !hit(int'(caddr), plev);

  smem_cmd_engine #(.ADDR_W(AW), .BUF_DEPTH(DEP), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .prot_level(plev), .chk_addr(caddr), .chk_ok(cok)
  );

  int checks = 0;
  int fails = 0;
  logic [7:0] expm [N];
  logic [7:0] wb [16];
  logic mwel = 1'b0;
  logic [1:0] mlvl = 2'b00;
  logic [7:0] d, s;

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      wt(H);
      r[i] = miso;
      sck = 1'b1;
      wt(H);
      sck = 1'b0;
    end
  endtask

  task automatic cs_on();
    cs_n = 1'b0;
    wt(H);
  endtask

  task automatic cs_off();
    wt(H);
    cs_n = 1'b1;
    wt(4 * H);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    cs_on();
    xfer(op, r);
    cs_off();
    if (op == 8'h06) mwel = 1'b1;
    if (op == 8'h04) mwel = 1'b0;
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] r;
    cs_on();
    xfer(8'h05, r);
    xfer(8'hA5, st);
    cs_off();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    cs_on();
    xfer(8'h01, r);
    xfer(v, r);
    xfer(8'hFF, r);
    cs_off();
    if (mwel) begin
      mlvl = v[3:2];
      mwel = 1'b0;
    end
  endtask

  task automatic write_n(input logic [15:0] a, input int n);
    logic [7:0] r;
    cs_on();
    xfer(8'h02, r);
    xfer(a[15:8], r);
    xfer(a[7:0], r);
    for (int k = 0; k < n; k++) xfer(wb[k], r);
    cs_off();
    if (mwel) begin
      for (int k = 0; k < n && k < DEP; k++) begin
        int ad;
        ad = (int'(a[7:0]) + k) % N;
        if (!hit(ad, mlvl)) expm[ad] = wb[k];
      end
      mwel = 1'b0;
    end
  endtask

  task automatic rd_check(input logic [15:0] a, input int n, input string req);
    logic [7:0] r;
    cs_on();
    xfer(8'h03, r);
    xfer(a[15:8], r);
    xfer(a[7:0], r);
    for (int k = 0; k < n; k++) begin
      xfer(8'((k * 53) ^ 8'h3C), r);
      check8(req, r, expm[(int'(a[7:0]) + k) % N]);
    end
    cs_off();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) expm[i] = 8'h00;
    wt(5);
    rst_n = 1'b1;
    wt(5);

    // R11 / R10: reset state
    check8("R10 miso idle", {7'd0, miso}, 8'h00);
    rdsr(s);
    check8("R11 reset status", s, 8'h00);
    rd_check(16'h0000, 4, "R11 reset array");

    // R3 / R6: latch set and cleared, repeated status bytes
    cmd1(8'h06);
    cs_on();
    xfer(8'h05, d);
    xfer(8'h00, s);
    check8("R6 status first", s, 8'h02);
    xfer(8'hFF, s);
    check8("R6 status repeat", s, 8'h02);
    cs_off();
    cmd1(8'h04);
    rdsr(s);
    check8("R3 latch cleared", s, 8'h00);

    // R3: write without the latch is dropped
    wb[0] = 8'hAA;
    write_n(16'h0005, 1);
    rdsr(s);
    check8("R3 no busy after dropped write", s, 8'h00);
    rd_check(16'h0005, 1, "R3 dropped write");

    // R4 / R8 / R9: sweep the whole array by block writes
    for (int blk = 0; blk < N / DEP; blk++) begin
      logic [15:0] a;
      a = {8'((blk * 37) | 8'h40), 8'(blk * DEP)};
      for (int k = 0; k < DEP; k++) wb[k] = 8'(((blk * DEP + k) * 7 + 3) ^ 8'h5A);
      cmd1(8'h06);
      write_n(a, DEP);
      rdsr(s);
      check8("R9 busy after commit, R8 latch cleared", s, 8'h01);
      wt(BUSY);
    end

    // R1 / R2: one continuous read crossing the top address
    rd_check(16'h7700, N + 4, "R1 R2 full read with wrap");

    // R9: commands during the busy window
    for (int k = 0; k < 2; k++) wb[k] = 8'(8'h11 * (k + 1));
    cmd1(8'h06);
    write_n(16'h0040, 2);
    cs_on();
    xfer(8'h06, d);
    cs_off();
    cs_on();
    xfer(8'h03, d);
    xfer(8'h00, d);
    xfer(8'h40, d);
    xfer(8'h00, d);
    cs_off();
    check8("R9 read dropped while busy", d, 8'h00);
    rdsr(s);
    check8("R9 latch not set while busy", s, 8'h01);
    wt(BUSY);
    rdsr(s);
    check8("R9 busy ended", s, 8'h00);
    rd_check(16'h0040, 2, "R9 write landed");

    // R4 / R8: chip-select rising mid-byte
    cmd1(8'h06);
    cs_on();
    xfer(8'h02, d);
    xfer(8'h00, d);
    xfer(8'h20, d);
    xfer(8'hEE, d);
    for (int i = 0; i < 3; i++) begin
      mosi = 1'b1;
      wt(H);
      sck = 1'b1;
      wt(H);
      sck = 1'b0;
    end
    cs_off();
    mwel = 1'b0;
    rdsr(s);
    check8("R4 no commit mid-byte, R8 latch cleared", s, 8'h00);
    rd_check(16'h0020, 1, "R4 mid-byte abort");

    // R4: overflow beyond the buffer, and wrap at the top
    for (int k = 0; k < 12; k++) wb[k] = 8'(8'hC0 + k);
    cmd1(8'h06);
    write_n(16'h0010, 12);
    wt(BUSY);
    rd_check(16'h0010, 12, "R4 extra bytes dropped");
    for (int k = 0; k < DEP; k++) wb[k] = 8'(8'h90 + k);
    cmd1(8'h06);
    write_n(16'h00FC, DEP);
    wt(BUSY);
    rd_check(16'h00FA, 12, "R4 write wraps");

    // R7: status write needs the latch
    wrsr(8'h04);
    rdsr(s);
    check8("R7 status write dropped", s, 8'h00);
    for (int lv = 1; lv < 4; lv++) begin
      logic [15:0] a;
      cmd1(8'h06);
      wrsr(8'(lv << 2));
      rdsr(s);
      check8("R7 level set, R8 latch cleared", s, 8'(lv << 2));
      a = (lv == 1) ? 16'h00BC : (lv == 2) ? 16'h007C : 16'h0000;
      for (int k = 0; k < DEP; k++) wb[k] = 8'(8'h30 + lv * 16 + k);
      cmd1(8'h06);
      write_n(a, DEP);
      wt(BUSY);
      rd_check(a - 16'd2, DEP + 4, "R5 protected region kept");
    end
    cmd1(8'h06);
    wrsr(8'h00);
    rdsr(s);
    check8("R7 level cleared", s, 8'h00);
    check8("R10 miso idle at end", {7'd0, miso}, 8'h00);

    rd_check(16'h0000, N + 2, "R2 final full read");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule